// File: doc/BRIEF.md
# SD host interrupt status logic

This block holds the normal-interrupt status of an SD card host controller. It watches level and pulse signals from the rest of the host: card presence, buffer read and write readiness, DMA boundary crossings, command and transfer completion, the DAT line busy flag, the stop-at-gap request and the card's own interrupt line. It turns edges and events on these signals into sticky status bits. Each bit has its own rule for when it sets.

Every status bit is gated by a status-enable bit. A second signal-enable mask selects which bits drive the single interrupt output. Software reaches the three registers through a synchronous word-wide port. It clears sticky bits by writing ones to them. The card interrupt bit is not latched. It tracks the sampled card line for as long as its enable stays set.

Top module: `sd_irq_status`

## Requirements
- R1: Under synchronous active-high reset, all status bits, both enable masks, `reg_rdata` and `irq_out` become 0.
- R2: Status bit 6 sets when `card_present` goes from 0 to 1, and status bit 7 sets when it goes from 1 to 0.
- R3: Status bit 5 sets only on a rising edge of `buf_rd_en`, and status bit 4 only on a rising edge of `buf_wr_en`. A level that stays high sets nothing further.
- R4: Status bit 3 sets on a `dma_boundary` pulse, except when `xfer_done` pulses in the same cycle. It also stays clear once a transfer has completed, until `dat_active` rises again.
- R5: Status bit 2 never sets while `stop_gap_req` is 0. With `xfer_is_read`=1, it sets on the cycle `dat_active` falls. With `xfer_is_read`=0, it sets one cycle after the fall, and only if `stop_gap_req` is still 1 then.
- R6: Status bit 8 takes the value of `card_irq_in` sampled each cycle while status-enable bit 8 is 1. Writing a one to status bit 8 has no effect.
- R7: A status bit whose status-enable bit is 0 is 0, and events that arrive while it is disabled are lost. A newly written enable value applies at the same clock edge.
- R8: Writing a 1 to a sticky status bit (bits 0 to 7) at address 0 clears it. If a set event hits the same bit in the same cycle, the bit stays 1.
- R9: Status bit 0 sets on a `cmd_done` pulse, and status bit 1 sets on an `xfer_done` pulse.
- R10: `irq_out` is 1 in the cycle after any bit is set in both the status register and the signal-enable mask, and 0 otherwise.
- R11: Address 0 reads the status, address 1 the status-enable mask and address 2 the signal-enable mask. Address 3 reads 0. Read data is registered with one cycle of latency, bits 15:9 read 0, and a write to address 1 or 2 stores data bits 8:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| card_present | input | 1 | Debounced card-present level |
| buf_rd_en | input | 1 | Buffer holds data ready to read |
| buf_wr_en | input | 1 | Buffer has room to write |
| dat_active | input | 1 | DAT line busy with a transfer |
| xfer_is_read | input | 1 | Current transfer direction is read |
| stop_gap_req | input | 1 | Stop-at-block-gap request control bit |
| dma_boundary | input | 1 | Pulse: DMA buffer boundary crossed |
| xfer_done | input | 1 | Pulse: transfer complete |
| cmd_done | input | 1 | Pulse: command complete |
| card_irq_in | input | 1 | Card interrupt line level |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench targets the cycles where two rules collide. These include a clear write that lands on the same edge as a set event, which would lose an event if the clear won. Another is a DMA boundary after transfer completion, which would raise a spurious DMA interrupt if the suppression were missing. It also covers a write-direction gap event where the stop request drops during the one-cycle delay, which would report a gap that was never honoured. It toggles the card-interrupt enable while the card line is high. A design that latched the line would keep bit 8 set after the enable drops, or would miss the restart once the enable returns. A long stretch of mixed traffic is compared every cycle against a behavioural model, so off-by-one latency on the read port or on `irq_out` shows up at once.

// File: rtl/sd_irq_pkg.sv
package sd_irq_pkg;
  // status bit positions (visible to software)
  localparam int BIT_CMD   = 0;
  localparam int BIT_XFER  = 1;
  localparam int BIT_GAP   = 2;
  localparam int BIT_DMA   = 3;
  localparam int BIT_WRRDY = 4;
  localparam int BIT_RDRDY = 5;
  localparam int BIT_INS   = 6;
  localparam int BIT_REM   = 7;
  localparam int BIT_CARD  = 8;
  localparam int N_STAT    = 9;

  // level inputs that need edge detection
  localparam int LV_CARD = 0;
  localparam int LV_RD   = 1;
  localparam int LV_WR   = 2;
  localparam int LV_DAT  = 3;
  localparam int N_LVL   = 4;

  // register addresses
  localparam int ADR_STAT  = 0;
  localparam int ADR_STEN  = 1;
  localparam int ADR_SIGEN = 2;
endpackage

// File: rtl/sd_irq_edge.sv
module sd_irq_edge #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] prev
);
  for (genvar g = 0; g < W; g++) begin : g_hold
    always_ff @(posedge clk) begin
      if (rst) prev[g] <= 1'b0;
      else     prev[g] <= lvl[g];
    end
  end
endmodule

// File: rtl/sd_irq_events.sv
module sd_irq_events
  import sd_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [N_LVL-1:0]  lvl,
  input  logic [N_LVL-1:0]  prev,
  input  logic              xfer_is_read,
  input  logic              stop_gap_req,
  input  logic              dma_boundary,
  input  logic              xfer_done,
  input  logic              cmd_done,
  input  logic              card_irq_in,
  output logic [N_STAT-1:0] set_vec
);
  logic [N_LVL-1:0] rise;
  logic [N_LVL-1:0] fall;
  logic             wgap_q;
  logic             done_q;

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      wgap_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      wgap_q <= fall[LV_DAT] & ~xfer_is_read;
      done_q <= xfer_done | (done_q & ~rise[LV_DAT]);
    end
  end

  always_comb begin
    set_vec             = '0;
    set_vec[BIT_CMD]    = cmd_done;
    set_vec[BIT_XFER]   = xfer_done;
    set_vec[BIT_GAP]    = stop_gap_req &
                          ((fall[LV_DAT] & xfer_is_read) | wgap_q);
    set_vec[BIT_DMA]    = dma_boundary & ~done_q & ~xfer_done;
    set_vec[BIT_WRRDY]  = rise[LV_WR];
    set_vec[BIT_RDRDY]  = rise[LV_RD];
    set_vec[BIT_INS]    = rise[LV_CARD];
    set_vec[BIT_REM]    = fall[LV_CARD];
    set_vec[BIT_CARD]   = card_irq_in;
  end

  logic unused_edges;
  assign unused_edges = fall[LV_RD] ^ fall[LV_WR];
endmodule

// File: rtl/sd_irq_regs.sv
module sd_irq_regs
  import sd_irq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_STAT-1:0] set_vec,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_out,
  output logic [N_STAT-1:0] stat_q,
  output logic [N_STAT-1:0] sten_q,
  output logic [N_STAT-1:0] sigen_q
);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(ADR_STAT);
  localparam logic [ADDR_W-1:0] A_STEN  = ADDR_W'(ADR_STEN);
  localparam logic [ADDR_W-1:0] A_SIGEN = ADDR_W'(ADR_SIGEN);

  logic [N_STAT-1:0] wfield;
  logic [N_STAT-1:0] sten_nxt;
  logic [N_STAT-1:0] clr;

  assign wfield = reg_wdata[N_STAT-1:0];

  always_comb begin
    sten_nxt = sten_q;
    if (reg_we && reg_addr == A_STEN) sten_nxt = wfield;
    clr = '0;
    if (reg_we && reg_addr == A_STAT) clr = wfield;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sten_q  <= '0;
      sigen_q <= '0;
    end else begin
      sten_q <= sten_nxt;
      if (reg_we && reg_addr == A_SIGEN) sigen_q <= wfield;
    end
  end

  for (genvar g = 0; g < N_STAT; g++) begin : g_bit
    if (g == BIT_CARD) begin : g_level
      always_ff @(posedge clk) begin
        if (rst) stat_q[g] <= 1'b0;
        else     stat_q[g] <= sten_nxt[g] & set_vec[g];
      end
    end else begin : g_sticky
      always_ff @(posedge clk) begin
        if (rst) stat_q[g] <= 1'b0;
        else     stat_q[g] <= sten_nxt[g] & (set_vec[g] | (stat_q[g] & ~clr[g]));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      irq_out <= |(stat_q & sigen_q);
      case (reg_addr)
        A_STAT:  reg_rdata <= DATA_W'(stat_q);
        A_STEN:  reg_rdata <= DATA_W'(sten_q);
        A_SIGEN: reg_rdata <= DATA_W'(sigen_q);
        default: reg_rdata <= '0;
      endcase
    end
  end

  logic unused_bits;
  assign unused_bits = (^reg_wdata[DATA_W-1:N_STAT]) ^ clr[BIT_CARD];
endmodule

// File: rtl/sd_irq_status.sv
module sd_irq_status
  import sd_irq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              card_present,
  input  logic              buf_rd_en,
  input  logic              buf_wr_en,
  input  logic              dat_active,
  input  logic              xfer_is_read,
  input  logic              stop_gap_req,
  input  logic              dma_boundary,
  input  logic              xfer_done,
  input  logic              cmd_done,
  input  logic              card_irq_in,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_out
);
  logic [N_LVL-1:0]  lvl;
  logic [N_LVL-1:0]  prev;
  logic [N_STAT-1:0] set_vec;
  logic [N_STAT-1:0] stat_q;
  logic [N_STAT-1:0] sten_q;
  logic [N_STAT-1:0] sigen_q;

  always_comb begin
    lvl         = '0;
    lvl[LV_CARD] = card_present;
    lvl[LV_RD]   = buf_rd_en;
    lvl[LV_WR]   = buf_wr_en;
    lvl[LV_DAT]  = dat_active;
  end

  sd_irq_edge #(.W(N_LVL)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (lvl),
    .prev (prev)
  );

  sd_irq_events u_events (
    .clk          (clk),
    .rst          (rst),
    .lvl          (lvl),
    .prev         (prev),
    .xfer_is_read (xfer_is_read),
    .stop_gap_req (stop_gap_req),
    .dma_boundary (dma_boundary),
    .xfer_done    (xfer_done),
    .cmd_done     (cmd_done),
    .card_irq_in  (card_irq_in),
    .set_vec      (set_vec)
  );

  sd_irq_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .set_vec   (set_vec),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out),
    .stat_q    (stat_q),
    .sten_q    (sten_q),
    .sigen_q   (sigen_q)
  );
endmodule

// File: rtl/sd_irq_checker.sv
module sd_irq_checker
  import sd_irq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              card_present,
  input logic              stop_gap_req,
  input logic              cmd_done,
  input logic              card_irq_in,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq_out,
  input logic [N_STAT-1:0] stat_q,
  input logic [N_STAT-1:0] sten_q,
  input logic [N_STAT-1:0] sigen_q
);
  logic sten_wr;
  logic stat_wr;
  assign sten_wr = reg_we && reg_addr == ADDR_W'(ADR_STEN);
  assign stat_wr = reg_we && reg_addr == ADDR_W'(ADR_STAT);

  assert_disabled_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (stat_q & ~sten_q) == '0);

  assert_irq_high_R10: assert property (@(posedge clk) disable iff (rst)
    |(stat_q & sigen_q) |=> irq_out);

  assert_irq_low_R10: assert property (@(posedge clk) disable iff (rst)
    !(|(stat_q & sigen_q)) |=> !irq_out);

  assert_no_gap_without_req_R5: assert property (@(posedge clk) disable iff (rst)
    !stop_gap_req && !stat_q[BIT_GAP] |=> !stat_q[BIT_GAP]);

  assert_card_line_tracked_R6: assert property (@(posedge clk) disable iff (rst)
    sten_q[BIT_CARD] && card_irq_in && !sten_wr |=> stat_q[BIT_CARD]);

  assert_insert_sets_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $rose(card_present) && sten_q[BIT_INS] && !sten_wr
      |=> stat_q[BIT_INS]);

  assert_cmd_sets_R9: assert property (@(posedge clk) disable iff (rst)
    cmd_done && sten_q[BIT_CMD] && !sten_wr |=> stat_q[BIT_CMD]);

  assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (rst)
    cmd_done && sten_q[BIT_CMD] && stat_wr && reg_wdata[BIT_CMD]
      |=> stat_q[BIT_CMD]);

  assert_upper_zero_R11: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[DATA_W-1:N_STAT] == '0);
endmodule

bind sd_irq_status sd_irq_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .card_present (card_present),
  .stop_gap_req (stop_gap_req),
  .cmd_done     (cmd_done),
  .card_irq_in  (card_irq_in),
  .reg_we       (reg_we),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .reg_rdata    (reg_rdata),
  .irq_out      (irq_out),
  .stat_q       (stat_q),
  .sten_q       (sten_q),
  .sigen_q      (sigen_q)
);

// File: tb/test_sd_irq_status.sv
module test_sd_irq_status;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic card_present = 0, buf_rd_en = 0, buf_wr_en = 0, dat_active = 0;
  logic xfer_is_read = 0, stop_gap_req = 0, dma_boundary = 0;
  logic xfer_done = 0, cmd_done = 0, card_irq_in = 0;
  logic reg_we = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic irq_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_irq_status #(.DATA_W(DW), .ADDR_W(AW)) i_sd_irq_status (
    .clk(clk), .rst(rst), .card_present(card_present), .buf_rd_en(buf_rd_en),
    .buf_wr_en(buf_wr_en), .dat_active(dat_active), .xfer_is_read(xfer_is_read),
    .stop_gap_req(stop_gap_req), .dma_boundary(dma_boundary),
    .xfer_done(xfer_done), .cmd_done(cmd_done), .card_irq_in(card_irq_in),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  int  n_chk = 0;
  int  n_fail = 0;
  bit  finished = 0;

  // ---------------- behavioural reference model ----------------
  bit [8:0]  m_st, m_sten, m_sig;
  bit [15:0] m_rdata;
  bit        m_irq;
  bit        p_card, p_rd, p_wr, p_dat, m_wpend, m_done;
  int        m_raddr;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_sten = 0; m_sig = 0; m_rdata = 0; m_irq = 0;
      p_card = 0; p_rd = 0; p_wr = 0; p_dat = 0; m_wpend = 0; m_done = 0;
      m_raddr = 0;
    end else begin
      bit [8:0] ev, nsten, wipe;
      int a;
      a = int'(reg_addr);
      m_raddr = a;
      if (a == 0)      m_rdata = {7'd0, m_st};
      else if (a == 1) m_rdata = {7'd0, m_sten};
      else if (a == 2) m_rdata = {7'd0, m_sig};
      else             m_rdata = 0;
      m_irq = (m_st & m_sig) != 0;

      ev = 0;
      if (cmd_done)  ev[0] = 1;
      if (xfer_done) ev[1] = 1;
      if (stop_gap_req && ((p_dat && !dat_active && xfer_is_read) || m_wpend)) ev[2] = 1;
      if (dma_boundary && !m_done && !xfer_done) ev[3] = 1;
      if (buf_wr_en && !p_wr) ev[4] = 1;
      if (buf_rd_en && !p_rd) ev[5] = 1;
      if (card_present && !p_card) ev[6] = 1;
      if (!card_present && p_card) ev[7] = 1;

      if (xfer_done) m_done = 1;
      else if (dat_active && !p_dat) m_done = 0;
      m_wpend = p_dat && !dat_active && !xfer_is_read;

      nsten = m_sten;
      wipe  = 0;
      if (reg_we && a == 1) nsten = reg_wdata[8:0];
      if (reg_we && a == 0) wipe = reg_wdata[8:0];
      if (reg_we && a == 2) m_sig = reg_wdata[8:0];
      for (int b = 0; b < 8; b++)
        m_st[b] = nsten[b] && (ev[b] || (m_st[b] && !wipe[b]));
      m_st[8] = nsten[8] && card_irq_in;
      m_sten = nsten;

      p_card = card_present; p_rd = buf_rd_en; p_wr = buf_wr_en; p_dat = dat_active;
    end
  end

  function automatic string req_of_bit(int b);
    case (b)
      0, 1:    return "R9";
      2:       return "R5";
      3:       return "R4";
      4, 5:    return "R3";
      6, 7:    return "R2";
      8:       return "R6";
      default: return "R11";
    endcase
  endfunction

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      n_chk++;
      if (irq_out !== m_irq) begin
        n_fail++;
        $display("FAIL R10 irq_out actual=%0b expected=%0b at %0t", irq_out, m_irq, $time);
      end
      n_chk++;
      if (reg_rdata !== m_rdata) begin
        int fb;
        string tag;
        fb = 15;
        for (int b = 15; b >= 0; b--) if (reg_rdata[b] !== m_rdata[b]) fb = b;
        tag = (m_raddr == 0) ? req_of_bit(fb) : "R11";
        n_fail++;
        $display("FAIL %s reg_rdata(addr %0d) actual=%h expected=%h at %0t",
                 tag, m_raddr, reg_rdata, m_rdata, $time);
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_we = 1; reg_addr = AW'(a); reg_wdata = DW'(d);
    @(negedge clk);
    reg_we = 0; reg_addr = '0;
  endtask

  task automatic rd(int a, output logic [DW-1:0] v);
    @(negedge clk);
    reg_we = 0; reg_addr = AW'(a);
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [DW-1:0] v;
    cyc(4);
    @(negedge clk) rst = 0;
    rd(0, v); chk("R1 status after reset", v, 0);
    rd(1, v); chk("R1 enable after reset", v, 0);
    chk("R1 irq after reset", irq_out, 0);

    // events while disabled are lost (R7)
    cmd_done = 1; @(negedge clk) cmd_done = 0;
    cyc(1); rd(0, v); chk("R7 disabled bit stays 0", v[0], 0);

    wr(1, 16'h1FF); wr(2, 16'h1FF);
    rd(1, v); chk("R11 enable readback", v, 16'h01FF);
    rd(3, v); chk("R11 unused address", v, 0);

    card_present = 1; cyc(2);
    rd(0, v); chk("R2 insertion bit6", v[6], 1);
    chk("R10 irq asserted", irq_out, 1);
    wr(0, 16'h0040); rd(0, v); chk("R8 clear bit6", v[6], 0);
    card_present = 0; cyc(2);
    rd(0, v); chk("R2 removal bit7", v[7], 1);

    buf_rd_en = 1; cyc(2); wr(0, 16'h0020); cyc(3);
    rd(0, v); chk("R3 level held no reset of bit5", v[5], 0);

    // block gap: no request -> nothing
    wr(0, 16'h00FF);
    dat_active = 1; cyc(2); dat_active = 0; cyc(3);
    rd(0, v); chk("R5 no gap without request", v[2], 0);
    stop_gap_req = 1; xfer_is_read = 1;
    dat_active = 1; cyc(2); dat_active = 0; cyc(2);
    rd(0, v); chk("R5 read gap event", v[2], 1);
    wr(0, 16'h0004);
    // write direction, request dropped during the delay
    xfer_is_read = 0; dat_active = 1; cyc(2);
    @(negedge clk) dat_active = 0;
    @(negedge clk) stop_gap_req = 0;
    cyc(2); rd(0, v); chk("R5 write gap needs request held", v[2], 0);

    // DMA suppression after transfer complete
    xfer_done = 1; @(negedge clk) xfer_done = 0;
    dma_boundary = 1; @(negedge clk) dma_boundary = 0;
    cyc(1); rd(0, v);
    chk("R9 transfer complete bit1", v[1], 1);
    chk("R4 boundary after completion ignored", v[3], 0);
    dat_active = 1; cyc(1);
    dma_boundary = 1; @(negedge clk) dma_boundary = 0;
    cyc(1); rd(0, v); chk("R4 boundary in new transfer", v[3], 1);

    // card interrupt follows level while enabled
    card_irq_in = 1; cyc(2);
    rd(0, v); chk("R6 card interrupt follows line", v[8], 1);
    wr(0, 16'h0100); rd(0, v); chk("R6 write-one ignored", v[8], 1);
    wr(1, 16'h00FF); rd(0, v); chk("R7 disable clears bit8", v[8], 0);
    wr(1, 16'h01FF); cyc(1); rd(0, v); chk("R6 sampling restarts", v[8], 1);
    card_irq_in = 0;

    // set wins over same-cycle clear
    wr(0, 16'h00FF);
    @(negedge clk);
    cmd_done = 1; reg_we = 1; reg_addr = 0; reg_wdata = 16'h0001;
    @(negedge clk);
    cmd_done = 0; reg_we = 0;
    rd(0, v); chk("R8 set beats clear", v[0], 1);

    wr(2, 0); cyc(2); chk("R10 irq masked", irq_out, 0);
    wr(2, 16'h1FF);

    // mixed traffic compared each cycle against the model
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if ($urandom_range(15) == 0) card_present = ~card_present;
      if ($urandom_range(7) == 0)  buf_rd_en = ~buf_rd_en;
      if ($urandom_range(7) == 0)  buf_wr_en = ~buf_wr_en;
      if ($urandom_range(5) == 0)  dat_active = ~dat_active;
      if ($urandom_range(15) == 0) xfer_is_read = ~xfer_is_read;
      if ($urandom_range(7) == 0)  stop_gap_req = ~stop_gap_req;
      if ($urandom_range(9) == 0)  card_irq_in = ~card_irq_in;
      dma_boundary = ($urandom_range(5) == 0);
      xfer_done    = ($urandom_range(11) == 0);
      cmd_done     = ($urandom_range(7) == 0);
      reg_addr     = AW'($urandom_range(3));
      reg_we       = ($urandom_range(4) == 0);
      reg_wdata    = DW'($urandom);
      if (reg_we && reg_addr != 0 && $urandom_range(3) != 0) reg_wdata = 16'h01FF;
    end
    @(negedge clk);
    reg_we = 0; dma_boundary = 0; xfer_done = 0; cmd_done = 0;
    cyc(3);
    finish_run();
  end
endmodule